// File: doc/BRIEF.md
# Synchronized Programmable Divider Pair

This block holds two programmable frequency dividers that work side by side: a feedback divider and a reference divider. Each one counts the cycles in which its own clock enable is high. After every N such cycles it gives a one-clock pulse. The feedback ratio ranges from 512 to 131071. The reference ratio ranges from 8 to 2047. Configuration registers elsewhere supply both ratios, and both dividers run on one system clock. The two enables stand for the two input signals being divided.

The dividers count only while the hardware power pin and the software power bit are both high. While either one is low, both counters are held at the start of a period and both outputs stay low. When the power condition becomes true, the two dividers start together from a full period, so their outputs begin with a known phase relationship. The phase comparator downstream therefore sees no random starting error.

A ratio input may change at any time without corrupting a period that is already in progress. A divider samples the ratio only when it reloads. A ratio below the legal minimum is raised to that minimum.

Top module: `dual_ratio_divider`

## Requirements
- R1: `fb_pulse` is high for exactly one clock cycle. It goes high in the cycle after the clock edge at which `fb_en` has been high for the Nth time in the current period, where N is the feedback ratio (512 to 131071).
- R2: `ref_pulse` behaves the same way on `ref_en`, with the reference ratio N (8 to 2047).
- R3: `running` equals `pwr_pin` AND `pwr_bit`. While `running` is low, neither divider counts, and both pulse outputs are low from the next clock edge onward.
- R4: In the first clock cycle in which `running` is high, each divider starts a full period. Its first pulse follows the Nth enabled edge counted from that cycle, whatever the counts were before power-down.
- R5: A new ratio takes effect only at reload. A period in progress keeps the length it had when it started. The ratio present at the terminal enabled edge sets the length of the next period. While powered down, the ratio present in the last cycle before `running` rises sets the length of the first period.
- R6: A feedback ratio below 512 is treated as 512.
- R7: A reference ratio below 8 is treated as 8.
- R8: While `rst_n` is low, `fb_pulse` and `ref_pulse` are low, and both dividers are set to a full period of the minimum ratio.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| pwr_pin | input | 1 | Hardware power-on input |
| pwr_bit | input | 1 | Software power-on configuration bit |
| fb_en | input | 1 | One cycle of the feedback input to be divided |
| ref_en | input | 1 | One cycle of the reference input to be divided |
| fb_ratio | input | 17 | Feedback divide ratio from configuration |
| ref_ratio | input | 11 | Reference divide ratio from configuration |
| fb_pulse | output | 1 | Feedback divider output pulse |
| ref_pulse | output | 1 | Reference divider output pulse |
| running | output | 1 | Both power conditions are true |

## Verification
The long random stretch uses enables that are high about three quarters of the time. This separates counting of enabled edges from counting of clock cycles. In the same stretch, ratio changes arrive at arbitrary points in a period, which exposes any divider that picks up a new ratio mid-count instead of at reload. Power toggles scattered through the run, together with a directed release, show whether both dividers restart from a full period or keep stale counts. Directed runs cover the following: ratios below the minimum, the largest feedback and reference ratios with the enables held high, and each power input held low on its own.

// File: rtl/dual_ratio_divider.sv
module dual_ratio_divider #(
  parameter int FB_W   = 17,
  parameter int FB_MIN = 512,
  parameter int REF_W  = 11,
  parameter int REF_MIN = 8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             pwr_pin,
  input  logic             pwr_bit,
  input  logic             fb_en,
  input  logic             ref_en,
  input  logic [FB_W-1:0]  fb_ratio,
  input  logic [REF_W-1:0] ref_ratio,
  output logic             fb_pulse,
  output logic             ref_pulse,
  output logic             running
);
  // the field widths bound the upper ratio limits
  localparam logic [FB_W-1:0]  FB_LO  = FB_W'(FB_MIN);
  localparam logic [REF_W-1:0] REF_LO = REF_W'(REF_MIN);

  logic [FB_W-1:0]  fb_req, fb_cnt;
  logic [REF_W-1:0] ref_req, ref_cnt;

  assign running = pwr_pin & pwr_bit;
  assign fb_req  = (fb_ratio  < FB_LO)  ? FB_LO  : fb_ratio;
  assign ref_req = (ref_ratio < REF_LO) ? REF_LO : ref_ratio;

  // counters hold remaining enabled edges minus one; the ratio is sampled only on reload
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      fb_cnt   <= FB_LO - 1'b1;
      fb_pulse <= 1'b0;
    end else if (!running) begin
      fb_cnt   <= fb_req - 1'b1;
      fb_pulse <= 1'b0;
    end else begin
      fb_pulse <= fb_en && (fb_cnt == '0);
      if (fb_en)
        fb_cnt <= (fb_cnt == '0) ? fb_req - 1'b1 : fb_cnt - 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ref_cnt   <= REF_LO - 1'b1;
      ref_pulse <= 1'b0;
    end else if (!running) begin
      ref_cnt   <= ref_req - 1'b1;
      ref_pulse <= 1'b0;
    end else begin
      ref_pulse <= ref_en && (ref_cnt == '0);
      if (ref_en)
        ref_cnt <= (ref_cnt == '0) ? ref_req - 1'b1 : ref_cnt - 1'b1;
    end
  end
endmodule

// File: rtl/dual_ratio_divider_chk.sv
module dual_ratio_divider_chk (
  input logic clk,
  input logic rst_n,
  input logic running,
  input logic fb_en,
  input logic ref_en,
  input logic fb_pulse,
  input logic ref_pulse
);
  AST_FB_SINGLE:   assert property (@(posedge clk) disable iff (!rst_n) fb_pulse |=> !fb_pulse);   // R1
  AST_FB_NEEDS_EN: assert property (@(posedge clk) disable iff (!rst_n) fb_pulse |-> $past(fb_en)); // R1
  AST_REF_SINGLE:  assert property (@(posedge clk) disable iff (!rst_n) ref_pulse |=> !ref_pulse); // R2
  AST_REF_NEEDS_EN: assert property (@(posedge clk) disable iff (!rst_n) ref_pulse |-> $past(ref_en)); // R2
  AST_OFF_QUIET:   assert property (@(posedge clk) disable iff (!rst_n) !running |=> !fb_pulse && !ref_pulse); // R3
  AST_RELEASE_GAP: assert property (@(posedge clk) disable iff (!rst_n) $rose(running) |=> !fb_pulse && !ref_pulse); // R4
endmodule

bind dual_ratio_divider dual_ratio_divider_chk u_chk (
  .clk(clk), .rst_n(rst_n), .running(running), .fb_en(fb_en),
  .ref_en(ref_en), .fb_pulse(fb_pulse), .ref_pulse(ref_pulse)
);

// File: tb/dual_ratio_divider_bench.sv
`timescale 1ns/1ps
module dual_ratio_divider_bench;
  logic clk = 1'b0, rst_n = 1'b0;
  logic pwr_pin = 1'b0, pwr_bit = 1'b0, fb_en = 1'b0, ref_en = 1'b0;
  logic [16:0] fb_ratio = 17'd600;
  logic [10:0] ref_ratio = 11'd20;
  wire fb_pulse, ref_pulse, running;

  int vectors = 0, errs = 0;
  bit finished = 1'b0;
  int m_fb_left = 512, m_ref_left = 8;
  bit e_fb = 1'b0, e_ref = 1'b0;

  always #2.5 clk = ~clk;

  dual_ratio_divider u_dual_ratio_divider (
    .clk(clk), .rst_n(rst_n), .pwr_pin(pwr_pin), .pwr_bit(pwr_bit),
    .fb_en(fb_en), .ref_en(ref_en), .fb_ratio(fb_ratio), .ref_ratio(ref_ratio),
    .fb_pulse(fb_pulse), .ref_pulse(ref_pulse), .running(running)
  );

  function automatic int lim_fb(int r);  return (r < 512) ? 512 : r; endfunction
  function automatic int lim_ref(int r); return (r < 8) ? 8 : r; endfunction

  task automatic compare(string tag);
    vectors++;
    if (fb_pulse !== e_fb) begin
      errs++; $display("FAIL %s fb_pulse actual=%0b expected=%0b", tag, fb_pulse, e_fb);
    end
    if (ref_pulse !== e_ref) begin
      errs++; $display("FAIL %s ref_pulse actual=%0b expected=%0b", tag, ref_pulse, e_ref);
    end
    if (running !== (pwr_pin & pwr_bit)) begin
      errs++; $display("FAIL R3 running actual=%0b expected=%0b", running, pwr_pin & pwr_bit);
    end
  endtask

  task automatic step(string tag);
    @(posedge clk);
    e_fb = 1'b0; e_ref = 1'b0;
    if (!(pwr_pin && pwr_bit)) begin
      m_fb_left = lim_fb(int'(fb_ratio));
      m_ref_left = lim_ref(int'(ref_ratio));
    end else begin
      if (fb_en) begin
        m_fb_left--;
        if (m_fb_left == 0) begin e_fb = 1'b1; m_fb_left = lim_fb(int'(fb_ratio)); end
      end
      if (ref_en) begin
        m_ref_left--;
        if (m_ref_left == 0) begin e_ref = 1'b1; m_ref_left = lim_ref(int'(ref_ratio)); end
      end
    end
    @(negedge clk);
    compare(tag);
  endtask

  task automatic run_n(int n, string tag);
    for (int i = 0; i < n; i++) step(tag);
  endtask

  initial begin
    void'($urandom(32'd20240611));
    repeat (3) @(negedge clk);
    compare("R8");
    rst_n = 1'b1;
    step("R8");

    // R3: each power input alone keeps the block idle
    fb_en = 1'b1; ref_en = 1'b1;
    pwr_pin = 1'b1; pwr_bit = 1'b0; run_n(600, "R3");
    pwr_pin = 1'b0; pwr_bit = 1'b1; run_n(600, "R3");
    pwr_pin = 1'b1; run_n(1300, "R1/R2");

    // random enables, mid-count ratio changes, occasional power toggles
    for (int i = 0; i < 20000; i++) begin
      fb_en  = ($urandom % 4) != 0;
      ref_en = ($urandom % 4) != 0;
      if ($urandom % 300 == 0) fb_ratio  = 17'(512 + $urandom % 200);
      if ($urandom % 300 == 0) ref_ratio = 11'(8 + $urandom % 60);
      if ($urandom % 2000 == 0) pwr_bit = ~pwr_bit;
      step("R1/R2/R5");
    end
    pwr_bit = 1'b1;

    // R5: directed mid-period change
    fb_en = 1'b1; ref_en = 1'b1;
    fb_ratio = 17'd600; ref_ratio = 11'd30;
    pwr_pin = 1'b0; step("R5"); pwr_pin = 1'b1;
    run_n(100, "R5");
    fb_ratio = 17'd520; ref_ratio = 11'd10;
    run_n(2000, "R5");

    // R4: release after power-down restarts both from a full period
    run_n(123, "R4");
    pwr_bit = 1'b0; run_n(5, "R4");
    pwr_bit = 1'b1; run_n(1500, "R4");

    // R6 and R7: below-minimum ratios
    fb_ratio = 17'd3; ref_ratio = 11'd2;
    pwr_pin = 1'b0; step("R6/R7"); pwr_pin = 1'b1;
    run_n(1100, "R6/R7");
    fb_ratio = 17'd0; ref_ratio = 11'd0;
    run_n(1100, "R6/R7");

    // R1 and R2 at the largest ratios
    fb_ratio = 17'd131071; ref_ratio = 11'd2047;
    pwr_pin = 1'b0; step("R1/R2"); pwr_pin = 1'b1;
    run_n(131080, "R1/R2");

    finished = 1'b1;
    $display("== %0d vectors applied, %0d miscompares ==", vectors, errs);
    $finish;
  end

  initial begin
    repeat (199000) @(posedge clk);
    if (!finished) begin
      errs++;
      $display("FAIL watchdog expired actual=hung expected=done");
      $display("== %0d vectors applied, %0d miscompares ==", vectors, errs);
      $finish;
    end
  end
endmodule